// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block carries out the stack work of a subroutine call or a subroutine return in a small processor. It owns the stack pointer and the frame pointer. On a call it pushes a two-word frame onto a stack that grows downward: first the return address, then the caller's frame pointer. It then points the frame pointer at the new frame and hands the call target back as the next program counter. On a return it unwinds that frame. It restores the caller's frame pointer from memory, reads back the return address as the next program counter, and leaves the stack pointer where it was before the call.

Every stack access is one 32-bit word transfer on a simple request/ready memory port. A request stays in place until the memory answers with ready, so slow memories only stretch the operation. The pipeline raises a call or return request for one cycle while the block is idle. It then waits for the single-cycle completion pulse before it raises the next request.

Top module: `frame_seq`

## Requirements
- R1: After a synchronous active-low reset, `stack_ptr` equals SP_INIT (0x100 by default), `frame_ptr` equals FP_INIT (0x100 by default), `next_pc` is 0, and `done` and `mem_req` are low.
- R2: A call first writes the return address to the word at stack_ptr minus 8 (`mem_we` high), and `stack_ptr` then drops by 8.
- R3: The second access of a call writes the old `frame_ptr` to the word at the lowered stack pointer minus 4. After the call, both `stack_ptr` and `frame_ptr` equal the value stack_ptr had before the call, minus 12.
- R4: The pushed return address is `cur_pc` + 6 when `call_kind` is 0 (a call with a 32-bit target word), and `cur_pc` + 2 when `call_kind` is 1 (a call through a register).
- R5: When a call ends, `next_pc` equals the `call_target` captured at the request. Given a memory latency of L wait cycles per access, `done` is high after the 2L+3rd rising edge, counting the edge that accepts the request as the first.
- R6: A return first copies `frame_ptr` into `stack_ptr`, then reads the word at that address into `frame_ptr` and adds 4 to `stack_ptr`. A return performs no memory writes.
- R7: The second access of a return reads the word at the stack pointer into `next_pc`, and `stack_ptr` then rises by 8. `done` is due on the same 2L+3 edge schedule as in R5.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R9: Call and return requests that arrive while an operation is in progress are ignored. If both requests are high in the same idle cycle, the call is taken and the return is dropped.
- R10: `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| call_req | input | 1 | Start a call (sampled when idle) |
| ret_req | input | 1 | Start a return (sampled when idle) |
| call_kind | input | 1 | 0: call with a 32-bit target word, 1: call through a register |
| cur_pc | input | 32 | Address of the call instruction |
| call_target | input | 32 | Destination of the call |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes on this cycle's rising edge |
| next_pc | output | 32 | Program counter to resume at |
| done | output | 1 | One-cycle completion pulse |
| stack_ptr | output | 32 | Current stack pointer |
| frame_ptr | output | 32 | Current frame pointer |

## Verification
Each operation makes two memory accesses. With L wait cycles per access, each access takes L+1 edges, so `done` appears after exactly 2L+3 edges counted from the accepting edge. At that point `next_pc`, `stack_ptr` and `frame_ptr` are already final. The bench counts edges from the request and samples at the falling edge after each rising edge. It compares the edge count to 2L+3 for L from 0 to 3 and checks the pointers and `next_pc` in the `done` cycle. It checks that `done` is low again one cycle later. During a wait cycle it checks that the first access's address and write enable are still in place.

// File: rtl/frame_seq_pkg.sv
// Shared types for the call/return frame sequencer.
// Assumes a single-issue requester that waits for done between requests.
package frame_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_RA = 3'd1,
        ST_PUSH_FP = 3'd2,
        ST_POP_FP  = 3'd3,
        ST_POP_PC  = 3'd4
    } seq_state_t;

    typedef enum logic {
        KIND_ABS = 1'b0,
        KIND_REG = 1'b1
    } call_kind_t;

endpackage

// File: rtl/frame_seq_fsm.sv
// Operation sequencer: walks the two memory accesses of a call or return.
// Assumes mem_ready is only meaningful while a request is outstanding.
module frame_seq_fsm
    import frame_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       call_req,
    input  logic       ret_req,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       step,
    output logic       call_start,
    output logic       ret_start,
    output logic       finish
);

    seq_state_t state_nx;

    // Request acceptance: only in idle, call has priority over return.
    always_comb begin
        call_start = (state == ST_IDLE) && call_req;
        ret_start  = (state == ST_IDLE) && ret_req && !call_req;
    end

    // An access completes when it is outstanding and memory is ready.
    always_comb begin
        step   = (state != ST_IDLE) && mem_ready;
        finish = step && ((state == ST_PUSH_FP) || (state == ST_POP_PC));
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (call_start)     state_nx = ST_PUSH_RA;
                else if (ret_start) state_nx = ST_POP_FP;
            end
            ST_PUSH_RA: if (step) state_nx = ST_PUSH_FP;
            ST_PUSH_FP: if (step) state_nx = ST_IDLE;
            ST_POP_FP:  if (step) state_nx = ST_POP_PC;
            ST_POP_PC:  if (step) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R9: a busy sequencer stays busy until its final access completes.
    p_stay_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && !finish |=> (state != ST_IDLE));

endmodule

// File: rtl/frame_seq_link.sv
// Return-address and target latch for calls.
// Assumes cur_pc, call_kind and call_target are valid in the accepting cycle.
module frame_seq_link
    import frame_seq_pkg::*;
#(
    parameter int W          = 32,
    parameter int SHORT_STEP = 2,
    parameter int LONG_STEP  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         kind,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] target,
    output logic [W-1:0] ret_addr,
    output logic [W-1:0] jump_addr
);

    localparam logic [W-1:0] SHORT_OFS = W'(SHORT_STEP);
    localparam logic [W-1:0] LONG_OFS  = W'(LONG_STEP);

    logic [W-1:0] step_ofs;

    // Instruction length selects how far past the call the caller resumes.
    always_comb step_ofs = (call_kind_t'(kind) == KIND_REG) ? SHORT_OFS : LONG_OFS;

    // Capture return address and destination when a call is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr  <= '0;
            jump_addr <= '0;
        end else if (load) begin
            ret_addr  <= pc + step_ofs;
            jump_addr <= target;
        end
    end

endmodule

// File: rtl/frame_seq_ptrs.sv
// Stack and frame pointer registers with the access-address generator.
// Assumes step is only asserted in a memory state of the sequencer.
module frame_seq_ptrs
    import frame_seq_pkg::*;
#(
    parameter int            W       = 32,
    parameter logic [W-1:0]  SP_INIT = 32'h0000_0100,
    parameter logic [W-1:0]  FP_INIT = 32'h0000_0100,
    parameter int            RA_GAP  = 8,
    parameter int            FP_GAP  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  seq_state_t   state,
    input  logic         step,
    input  logic         ret_start,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] sp,
    output logic [W-1:0] fp,
    output logic [W-1:0] acc_addr
);

    localparam logic [W-1:0] RA_OFS = W'(RA_GAP);
    localparam logic [W-1:0] FP_OFS = W'(FP_GAP);

    // Address of the current access, taken from the pointer before update.
    always_comb begin
        unique case (state)
            ST_PUSH_RA: acc_addr = sp - RA_OFS;
            ST_PUSH_FP: acc_addr = sp - FP_OFS;
            default:    acc_addr = sp;
        endcase
    end

    // Pointer updates as each access completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_INIT;
            fp <= FP_INIT;
        end else if (ret_start) begin
            sp <= fp;
        end else if (step) begin
            unique case (state)
                ST_PUSH_RA: sp <= sp - RA_OFS;
                ST_PUSH_FP: begin
                    sp <= sp - FP_OFS;
                    fp <= sp - FP_OFS;
                end
                ST_POP_FP: begin
                    fp <= rdata;
                    sp <= sp + FP_OFS;
                end
                ST_POP_PC: sp <= sp + RA_OFS;
                default: ;
            endcase
        end
    end

    // R3: after the frame-pointer push the two pointers coincide.
    p_frame_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_FP) && step |=> (fp == sp));

    // R6: a return begins by moving the frame pointer into the stack pointer.
    p_unwind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_start |=> (sp == $past(fp)));

endmodule

// File: rtl/frame_seq.sv
// Call/return stack frame sequencer top.
// Pushes or pops a two-word frame over a request/ready word memory port.
// Assumes the requester holds off new requests until done.
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int            W       = 32,
    parameter logic [W-1:0]  SP_INIT = 32'h0000_0100,
    parameter logic [W-1:0]  FP_INIT = 32'h0000_0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         call_req,
    input  logic         ret_req,
    input  logic         call_kind,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] call_target,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic [W-1:0] next_pc,
    output logic         done,
    output logic [W-1:0] stack_ptr,
    output logic [W-1:0] frame_ptr
);

    seq_state_t   state;
    logic         step, call_start, ret_start, finish;
    logic [W-1:0] ret_addr, jump_addr;

    frame_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_req   (call_req),
        .ret_req    (ret_req),
        .mem_ready  (mem_ready),
        .state      (state),
        .step       (step),
        .call_start (call_start),
        .ret_start  (ret_start),
        .finish     (finish)
    );

    frame_seq_link #(.W(W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (call_start),
        .kind      (call_kind),
        .pc        (cur_pc),
        .target    (call_target),
        .ret_addr  (ret_addr),
        .jump_addr (jump_addr)
    );

    frame_seq_ptrs #(.W(W), .SP_INIT(SP_INIT), .FP_INIT(FP_INIT)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .step      (step),
        .ret_start (ret_start),
        .rdata     (mem_rdata),
        .sp        (stack_ptr),
        .fp        (frame_ptr),
        .acc_addr  (mem_addr)
    );

    // Memory request, direction and write data follow the current state.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_PUSH_RA) || (state == ST_PUSH_FP);
        mem_wdata = (state == ST_PUSH_RA) ? ret_addr : frame_ptr;
    end

    // Next PC and completion pulse, registered on the final access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (finish) next_pc <= (state == ST_PUSH_FP) ? jump_addr : mem_rdata;
        end
    end

    // R8: an unanswered request keeps its address, direction and data.
    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    // R10: the completion pulse never lasts two cycles.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion leaves the port idle.
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R2: the first access of a call is a write below the stack pointer.
    p_push_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> (mem_addr == stack_ptr - 32'd8));

endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        call_req, ret_req, call_kind;
    logic [31:0] cur_pc, call_target;
    logic        mem_req, mem_we, mem_ready, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, next_pc, stack_ptr, frame_ptr;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    frame_seq uut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .call_kind(call_kind), .cur_pc(cur_pc), .call_target(call_target),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .next_pc(next_pc), .done(done), .stack_ptr(stack_ptr), .frame_ptr(frame_ptr)
    );

    // Memory model: 64 words, programmable wait cycles, write log.
    logic [31:0] mem [0:63];
    logic [31:0] wlog_addr [0:3];
    logic [31:0] wlog_data [0:3];
    int          wn = 0;
    int          wcnt = 0;
    int          lat = 0;
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;

    assign mem_ready = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (poke_en) mem[poke_idx] <= poke_val;
        if (mem_req && mem_ready) begin
            wcnt <= 0;
            if (mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                wlog_addr[wn % 4]  <= mem_addr;
                wlog_data[wn % 4]  <= mem_wdata;
                wn <= wn + 1;
            end
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of the pointers and the pushed return addresses.
    logic [31:0] m_sp, m_fp;
    logic [31:0] ra_stack [0:7];
    int          depth = 0;

    task automatic do_call(input logic k, input logic [31:0] pc, input logic [31:0] tgt,
                           input int L, input logic both);
        int n;
        int base;
        logic [31:0] ra;
        lat  = L;
        base = wn;
        ra   = pc + (k ? 32'd2 : 32'd6);
        @(negedge clk);
        call_kind = k; cur_pc = pc; call_target = tgt; call_req = 1'b1; ret_req = both;
        @(posedge clk); n = 1;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b1;   // ignored while busy (R9)
        check("R2 first access address", mem_addr, m_sp - 32'd8);
        check("R2 first access is write", {31'd0, mem_we}, 32'd1);
        @(posedge clk); n++;
        @(negedge clk);
        ret_req = 1'b0;
        if (L >= 1) begin
            check("R8 address held in wait", mem_addr, m_sp - 32'd8);
            check("R8 request held in wait", {31'd0, mem_req & mem_we}, 32'd1);
        end
        while (!done && n < 40) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check("R5 call latency", n, 2 * L + 3);
        check("R5 call next_pc", next_pc, tgt);
        check("R2 write count", wn - base, 2);
        check("R2 return address slot", wlog_addr[base % 4], m_sp - 32'd8);
        check("R4 return address value", wlog_data[base % 4], ra);
        check("R3 old fp slot", wlog_addr[(base + 1) % 4], m_sp - 32'd12);
        check("R3 old fp value", wlog_data[(base + 1) % 4], m_fp);
        check("R3 stack_ptr after call", stack_ptr, m_sp - 32'd12);
        check("R3 frame_ptr after call", frame_ptr, m_sp - 32'd12);
        @(negedge clk);
        check("R10 done falls", {31'd0, done}, 32'd0);
        check("R9 no extra operation", {31'd0, mem_req}, 32'd0);
        ra_stack[depth] = ra;
        depth++;
        m_sp = m_sp - 32'd12;
        m_fp = m_sp;
    endtask

    task automatic do_ret(input int L, input logic [31:0] exp_pc,
                          input logic [31:0] exp_sp, input logic [31:0] exp_fp);
        int n;
        int base;
        lat  = L;
        base = wn;
        @(negedge clk);
        ret_req = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk);
        ret_req = 1'b0; call_req = 1'b1;   // ignored while busy (R9)
        check("R6 first read address", mem_addr, m_fp);
        check("R6 first access is read", {31'd0, mem_we}, 32'd0);
        @(posedge clk); n++;
        @(negedge clk);
        call_req = 1'b0;
        while (!done && n < 40) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check("R7 return latency", n, 2 * L + 3);
        check("R7 return next_pc", next_pc, exp_pc);
        check("R7 stack_ptr after return", stack_ptr, exp_sp);
        check("R6 frame_ptr after return", frame_ptr, exp_fp);
        check("R6 no writes on return", wn - base, 0);
        @(negedge clk);
        check("R10 done falls after return", {31'd0, done}, 32'd0);
        check("R9 no call started while busy", wn - base, 0);
        depth--;
        m_sp = exp_sp;
        m_fp = exp_fp;
    endtask

    initial begin
        #(8 * 100000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] sp0, fp0, sp1, fp1;
        rst_n = 1'b0; call_req = 1'b0; ret_req = 1'b0; call_kind = 1'b0;
        cur_pc = '0; call_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset stack_ptr", stack_ptr, 32'h100);
        check("R1 reset frame_ptr", frame_ptr, 32'h100);
        check("R1 reset next_pc", next_pc, 32'h0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
        m_sp = 32'h100;
        m_fp = 32'h100;

        // Sweep latency and call kind: call then return.
        for (int L = 0; L < 4; L++) begin
            for (int k = 0; k < 2; k++) begin
                sp0 = m_sp; fp0 = m_fp;
                do_call(k[0], 32'h0000_1000 + 32'(L * 64 + k * 16),
                        32'h0000_8000 + 32'(L * 256 + k * 4), L, 1'b0);
                do_ret(L, ra_stack[depth - 1], sp0, fp0);
            end
        end

        // Nested frames.
        sp0 = m_sp; fp0 = m_fp;
        do_call(1'b0, 32'h0000_2000, 32'h0000_3000, 1, 1'b0);
        sp1 = m_sp; fp1 = m_fp;
        do_call(1'b1, 32'h0000_3010, 32'h0000_4000, 2, 1'b0);
        do_ret(0, ra_stack[depth - 1], sp1, fp1);
        do_ret(3, ra_stack[depth - 1], sp0, fp0);

        // Simultaneous requests: call wins (R9).
        sp0 = m_sp; fp0 = m_fp;
        do_call(1'b1, 32'h0000_5000, 32'h0000_6000, 0, 1'b1);

        // Return uses memory contents: overwrite the return-address slot.
        @(negedge clk);
        poke_en = 1'b1; poke_idx = m_fp[7:2] + 6'd1; poke_val = 32'hDEAD_BEE0;
        @(negedge clk);
        poke_en = 1'b0;
        do_ret(1, 32'hDEAD_BEE0, sp0, fp0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule